// File: doc/BRIEF.md
# Binary/Decimal Arithmetic-Logic Unit with Status Flags

This block is the 8-bit arithmetic and logic unit of a small accumulator-style processor whose status byte carries a decimal-mode bit. Each cycle it takes a register operand (the accumulator, or an index register for compares), a second operand, the current status byte and an operation code. One clock later it presents the result byte and a new status byte in which only the flags the operation owns have been rewritten.

Addition and subtraction run in plain binary or, when the decimal bit is set, in packed BCD. The binary sum or difference is formed first and then corrected digit by digit. Carry acts as an inverted borrow for subtraction and compare. Logic, shift, rotate, increment, decrement, bit-test and test-and-modify operations share one unit with per-flag write enables, so the flags an operation does not own pass through unchanged. The sequencer that owns the register file writes the result back where it belongs.

Top module: `bcd_alu`

## Requirements
- R1: Result and status are registered, so inputs presented before a rising edge appear on the outputs after that edge. A synchronous active-high reset clears the result to 0x00 and the status to 0x20.
- R2: The status byte holds N in bit 7, V in bit 6, a constant 1 in bit 5, B in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0. Output bit 5 is always 1, and bits 4..2 are copied from the input status for every operation.
- R3: Op 0 (add with carry) with D=0 returns A+B+C mod 256. C is the carry out, V is set when both operands share a sign that the result does not, and N and Z come from the result.
- R4: Op 0 with D=1 on valid BCD operands returns the packed-BCD value of (A+B+C) mod 100, with C set when the decimal sum reaches 100. N and Z come from the corrected result, and V takes the binary-mode value.
- R5: Op 1 (subtract with borrow) with D=0 returns A-B-(1-C) mod 256. C=1 means no borrow occurred, V is the signed overflow of the subtraction, and N and Z come from the result.
- R6: Op 1 with D=1 on valid BCD operands returns the packed-BCD value of (A-B-(1-C)) mod 100, with C=1 when no decimal borrow occurred. N and Z come from the corrected result, and V takes the binary-mode value.
- R7: Op 2 (compare) ignores the incoming C and D. It returns the register operand unchanged, sets C when register >= operand as unsigned values, sets Z on equality, copies N from bit 7 of the 8-bit difference, and keeps V.
- R8: Ops 3, 4, 5 and 6 (AND, OR, XOR, pass operand) return the result with N and Z from it and V and C kept. Op codes 17 to 31 return the register operand and change no flag.
- R9: Ops 7 and 8 (increment and decrement of the second operand) wrap modulo 256, set N and Z from the result, and keep V and C.
- R10: Ops 9, 10, 11 and 12 (shift left, shift right, rotate left, rotate right of the second operand) move the bit shifted out into C. Rotates insert the old C at the vacated end, and shifts insert 0. N and Z come from the result and V is kept.
- R11: Op 13 (bit test, memory form) copies operand bit 7 to N and bit 6 to V, sets Z when (register AND operand) is zero, keeps C, and returns the register operand.
- R12: Op 14 (bit test, immediate form) changes only Z, set when (register AND operand) is zero, and returns the register operand.
- R13: Op 15 returns (operand OR register) and op 16 returns (operand AND NOT register). Both set Z from (register AND original operand) and keep N, V and C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| reg_i | input | 8 | Register operand (accumulator or index register) |
| opnd_i | input | 8 | Second operand |
| stat_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Registered result |
| stat_o | output | 8 | Registered updated status byte |

## Verification
The hardest case to reach is a decimal addition where a digit carry comes from the +0x66 correction step rather than from the first binary sum. Examples are a low digit summing to 10..15, or a high digit reaching 0x9A only after the low-digit carry. Subtractions that borrow in one digit but not the other are the matching hard case. Only specific digit pairs with a specific carry-in produce these. The bench therefore sweeps every pair of valid BCD operands with both carry-in values in both directions, so every digit-carry and digit-borrow combination occurs. The binary paths are swept over all first operands against a stride of second operands.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DW   = 8;
    localparam int OPW  = 5;
    localparam int NIB  = 4;

    // status bit positions
    localparam int SB_N   = 7;
    localparam int SB_V   = 6;
    localparam int SB_ONE = 5;
    localparam int SB_BRK = 4;
    localparam int SB_DEC = 3;
    localparam int SB_IRQ = 2;
    localparam int SB_Z   = 1;
    localparam int SB_C   = 0;

    localparam logic [DW-1:0] STAT_RST = DW'(1) << SB_ONE;
    localparam logic [DW-1:0] LO_FIX   = 8'h06;
    localparam logic [DW-1:0] HI_FIX   = 8'h60;
    localparam logic [DW-1:0] BOTH_FIX = LO_FIX | HI_FIX;

    typedef enum logic [OPW-1:0] {
        OP_ADC  = 5'd0,
        OP_SBC  = 5'd1,
        OP_CMP  = 5'd2,
        OP_AND  = 5'd3,
        OP_OR   = 5'd4,
        OP_XOR  = 5'd5,
        OP_PASS = 5'd6,
        OP_INC  = 5'd7,
        OP_DEC  = 5'd8,
        OP_SHL  = 5'd9,
        OP_SHR  = 5'd10,
        OP_ROTL = 5'd11,
        OP_ROTR = 5'd12,
        OP_BITM = 5'd13,
        OP_BITI = 5'd14,
        OP_TSET = 5'd15,
        OP_TCLR = 5'd16
    } op_e;

    // per-flag write enables and values
    typedef struct packed {
        logic wn, wv, wz, wc;
        logic n, v, z, c;
    } flag_upd_t;

    typedef struct packed {
        logic [DW-1:0] res;
        flag_upd_t     fl;
    } alu_out_t;

    function automatic logic is_zero(input logic [DW-1:0] x);
        return x == '0;
    endfunction

    function automatic flag_upd_t nz_only(input logic [DW-1:0] x);
        flag_upd_t f;
        f    = '0;
        f.wn = 1'b1;
        f.wz = 1'b1;
        f.n  = x[DW-1];
        f.z  = is_zero(x);
        return f;
    endfunction

endpackage

// File: rtl/bcd_alu_addsub.sv
module bcd_alu_addsub
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    input  logic          dec_i,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] bin_o,
    output logic          cout_o,
    output logic          ovf_o
);

    logic [DW-1:0]  bx;
    logic [DW:0]    s_bin;
    logic [NIB:0]   lo_bin;
    logic           lo_c1;
    logic [NIB:0]   lo_adj;
    logic [DW:0]    s_adj;
    logic           lo_carry;
    logic           hi_carry;
    logic [DW-1:0]  add_fix;
    logic [DW-1:0]  sub_fix;

    always_comb begin
        bx     = sub_i ? ~b_i : b_i;
        s_bin  = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cin_i};
        lo_bin = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        lo_c1  = lo_bin[NIB];
        ovf_o  = (a_i[DW-1] == bx[DW-1]) && (s_bin[DW-1] != a_i[DW-1]);

        // decimal add: bias both digits by six, then remove the bias from
        // any digit that produced no carry in either step
        lo_adj   = {1'b0, s_bin[NIB-1:0]} + {1'b0, LO_FIX[NIB-1:0]};
        s_adj    = {1'b0, s_bin[DW-1:0]} + {1'b0, BOTH_FIX};
        lo_carry = lo_c1 | lo_adj[NIB];
        hi_carry = s_bin[DW] | s_adj[DW];
        add_fix  = (lo_carry ? '0 : LO_FIX) | (hi_carry ? '0 : HI_FIX);

        // decimal subtract: remove six from each digit that borrowed
        sub_fix  = (lo_c1 ? '0 : LO_FIX) | (s_bin[DW] ? '0 : HI_FIX);

        bin_o = s_bin[DW-1:0];
        if (!dec_i) begin
            sum_o  = s_bin[DW-1:0];
            cout_o = s_bin[DW];
        end else if (sub_i) begin
            sum_o  = s_bin[DW-1:0] - sub_fix;
            cout_o = s_bin[DW];
        end else begin
            sum_o  = s_adj[DW-1:0] - add_fix;
            cout_o = hi_carry;
        end
    end

endmodule

// File: rtl/bcd_alu_misc.sv
module bcd_alu_misc
    import bcd_alu_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           cin_i,
    output alu_out_t       out_o
);

    logic [DW-1:0] masked;

    always_comb begin
        masked    = a_i & b_i;
        out_o     = '0;
        out_o.res = a_i;
        case (op_i)
            OP_AND:  begin out_o.res = a_i & b_i; out_o.fl = nz_only(out_o.res); end
            OP_OR:   begin out_o.res = a_i | b_i; out_o.fl = nz_only(out_o.res); end
            OP_XOR:  begin out_o.res = a_i ^ b_i; out_o.fl = nz_only(out_o.res); end
            OP_PASS: begin out_o.res = b_i;       out_o.fl = nz_only(out_o.res); end
            OP_INC:  begin out_o.res = b_i + 1'b1; out_o.fl = nz_only(out_o.res); end
            OP_DEC:  begin out_o.res = b_i - 1'b1; out_o.fl = nz_only(out_o.res); end
            OP_SHL, OP_ROTL: begin
                out_o.res   = {b_i[DW-2:0], (op_i == OP_ROTL) ? cin_i : 1'b0};
                out_o.fl    = nz_only(out_o.res);
                out_o.fl.wc = 1'b1;
                out_o.fl.c  = b_i[DW-1];
            end
            OP_SHR, OP_ROTR: begin
                out_o.res   = {(op_i == OP_ROTR) ? cin_i : 1'b0, b_i[DW-1:1]};
                out_o.fl    = nz_only(out_o.res);
                out_o.fl.wc = 1'b1;
                out_o.fl.c  = b_i[0];
            end
            OP_BITM: begin
                out_o.fl.wn = 1'b1;
                out_o.fl.wv = 1'b1;
                out_o.fl.wz = 1'b1;
                out_o.fl.n  = b_i[DW-1];
                out_o.fl.v  = b_i[DW-2];
                out_o.fl.z  = is_zero(masked);
            end
            OP_BITI: begin
                out_o.fl.wz = 1'b1;
                out_o.fl.z  = is_zero(masked);
            end
            OP_TSET: begin
                out_o.res   = b_i | a_i;
                out_o.fl.wz = 1'b1;
                out_o.fl.z  = is_zero(masked);
            end
            OP_TCLR: begin
                out_o.res   = b_i & ~a_i;
                out_o.fl.wz = 1'b1;
                out_o.fl.z  = is_zero(masked);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  reg_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic [DW-1:0]  stat_i,
    output logic [DW-1:0]  res_o,
    output logic [DW-1:0]  stat_o
);

    logic          is_add, is_sub, is_cmp;
    logic          as_cin, as_dec;
    logic [DW-1:0] as_sum, as_bin;
    logic          as_cout, as_ovf;
    alu_out_t      misc_out;
    alu_out_t      sel;
    logic [DW-1:0] stat_nx;
    logic [DW-1:0] res_q, stat_q;

    assign is_add = (op_i == OP_ADC);
    assign is_sub = (op_i == OP_SBC);
    assign is_cmp = (op_i == OP_CMP);
    assign as_cin = is_cmp ? 1'b1 : stat_i[SB_C];
    assign as_dec = stat_i[SB_DEC] & ~is_cmp;

    bcd_alu_addsub u_addsub (
        .a_i    (reg_i),
        .b_i    (opnd_i),
        .cin_i  (as_cin),
        .sub_i  (is_sub | is_cmp),
        .dec_i  (as_dec),
        .sum_o  (as_sum),
        .bin_o  (as_bin),
        .cout_o (as_cout),
        .ovf_o  (as_ovf)
    );

    bcd_alu_misc u_misc (
        .op_i  (op_i),
        .a_i   (reg_i),
        .b_i   (opnd_i),
        .cin_i (stat_i[SB_C]),
        .out_o (misc_out)
    );

    always_comb begin
        sel = misc_out;
        if (is_add || is_sub) begin
            sel.res   = as_sum;
            sel.fl    = nz_only(as_sum);
            sel.fl.wv = 1'b1;
            sel.fl.v  = as_ovf;
            sel.fl.wc = 1'b1;
            sel.fl.c  = as_cout;
        end else if (is_cmp) begin
            sel.res   = reg_i;
            sel.fl    = nz_only(as_bin);
            sel.fl.wc = 1'b1;
            sel.fl.c  = as_cout;
        end
    end

    // merge updated flags into the status byte
    always_comb begin
        stat_nx         = stat_i;
        stat_nx[SB_ONE] = 1'b1;
        if (sel.fl.wn) stat_nx[SB_N] = sel.fl.n;
        if (sel.fl.wv) stat_nx[SB_V] = sel.fl.v;
        if (sel.fl.wz) stat_nx[SB_Z] = sel.fl.z;
        if (sel.fl.wc) stat_nx[SB_C] = sel.fl.c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            stat_q <= STAT_RST;
        end else begin
            res_q  <= sel.res;
            stat_q <= stat_nx;
        end
    end

    assign res_o  = res_q;
    assign stat_o = stat_q;

endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
    import bcd_alu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  reg_i,
    input logic [DW-1:0]  opnd_i,
    input logic [DW-1:0]  stat_i,
    input logic [DW-1:0]  res_o,
    input logic [DW-1:0]  stat_o
);

    logic logic_op;
    assign logic_op = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                      (op_i == OP_PASS) || (op_i == OP_INC) || (op_i == OP_DEC);

    assert_one_bit_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stat_o[SB_ONE]);

    assert_keep_bdi_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stat_o[SB_BRK:SB_IRQ] == $past(stat_i[SB_BRK:SB_IRQ]));

    assert_logic_cv_R8: assert property (@(posedge clk) disable iff (rst)
        logic_op |=> (stat_o[SB_V] == $past(stat_i[SB_V])) && (stat_o[SB_C] == $past(stat_i[SB_C])));

    assert_logic_z_R8: assert property (@(posedge clk) disable iff (rst)
        logic_op |=> stat_o[SB_Z] == (res_o == '0));

    assert_cmp_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP) |=> (res_o == $past(reg_i)) && (stat_o[SB_V] == $past(stat_i[SB_V])));

    assert_biti_only_z_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BITI) |=> (stat_o[SB_N:SB_V] == $past(stat_i[SB_N:SB_V])) &&
                              (stat_o[SB_C] == $past(stat_i[SB_C])) && (res_o == $past(reg_i)));

    assert_tmod_keep_R13: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_TSET || op_i == OP_TCLR) |=>
            (stat_o[SB_N:SB_V] == $past(stat_i[SB_N:SB_V])) && (stat_o[SB_C] == $past(stat_i[SB_C])));

endmodule

bind bcd_alu bcd_alu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .reg_i  (reg_i),
    .opnd_i (opnd_i),
    .stat_i (stat_i),
    .res_o  (res_o),
    .stat_o (stat_o)
);

// File: tb/bcd_alu_test.sv
module bcd_alu_test;
    import bcd_alu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] op;
    logic [7:0] ra, rb, st;
    logic [7:0] res_o, stat_o;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_alu uut (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .reg_i  (ra),
        .opnd_i (rb),
        .stat_i (st),
        .res_o  (res_o),
        .stat_o (stat_o)
    );

    // mask: 8=N 4=V 2=Z 1=C
    function automatic logic [7:0] fl(input logic [7:0] s, input int mask,
                                      input logic n, v, z, c);
        logic [7:0] r;
        r = s;
        if (mask & 8) r[7] = n;
        if (mask & 4) r[6] = v;
        if (mask & 2) r[1] = z;
        if (mask & 1) r[0] = c;
        r[5] = 1'b1;
        return r;
    endfunction

    function automatic int sgn(input logic [7:0] x);
        return (x >= 128) ? int'(x) - 256 : int'(x);
    endfunction

    function automatic logic [7:0] to_bcd(input int x);
        return 8'(((x / 10) << 4) | (x % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    task automatic run(input logic [4:0] o, input logic [7:0] a, b, s,
                       input logic [7:0] er, es, input string tag);
        op = o; ra = a; rb = b; st = s;
        @(negedge clk);
        checks++;
        if (res_o !== er || stat_o !== es) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h s=%h: res=%h stat=%h expected res=%h stat=%h",
                     tag, o, a, b, s, res_o, stat_o, er, es);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; op = '0; ra = '0; rb = '0; st = '0;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (res_o !== 8'h00 || stat_o !== 8'h20) begin
            fails++;
            $display("FAIL R1 reset: res=%h stat=%h expected res=00 stat=20", res_o, stat_o);
        end
        rst = 1'b0;

        // R1 R2 R3 binary add
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] s;
                    int t, sv;
                    s  = 8'(a * 7 + b) & 8'hF6 | 8'(c);
                    t  = a + b + c;
                    sv = sgn(8'(a)) + sgn(8'(b)) + c;
                    run(OP_ADC, 8'(a), 8'(b), s, 8'(t),
                        fl(s, 15, t[7], (sv > 127 || sv < -128), (t % 256) == 0, t > 255), "R3");
                end

        // R2 R5 binary subtract
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] s;
                    int t, sv;
                    s  = 8'(a + b * 3) & 8'hF6 | 8'(c);
                    t  = a - b - (1 - c);
                    sv = sgn(8'(a)) - sgn(8'(b)) - (1 - c);
                    run(OP_SBC, 8'(a), 8'(b), s, 8'(t),
                        fl(s, 15, t[7], (sv > 127 || sv < -128), (t & 255) == 0, t >= 0), "R5");
                end

        // R4 decimal add, R6 decimal subtract
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++)
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] s, ba, bb, r;
                    int t, sv;
                    ba = to_bcd(a); bb = to_bcd(b);
                    s  = 8'(a ^ b) | 8'h08;
                    s[0] = c[0];
                    t  = a + b + c;
                    r  = to_bcd(t % 100);
                    sv = sgn(ba) + sgn(bb) + c;
                    run(OP_ADC, ba, bb, s, r,
                        fl(s, 15, r[7], (sv > 127 || sv < -128), r == 0, t >= 100), "R4");
                    t  = a - b - (1 - c);
                    r  = to_bcd((t + 100) % 100);
                    sv = sgn(ba) - sgn(bb) - (1 - c);
                    run(OP_SBC, ba, bb, s, r,
                        fl(s, 15, r[7], (sv > 127 || sv < -128), r == 0, t >= 0), "R6");
                end

        // R7 compare; incoming C and D ignored
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5) begin
                logic [7:0] s, d;
                s = 8'(a * 5 + b);
                d = 8'(a - b);
                run(OP_CMP, 8'(a), 8'(b), s, 8'(a), fl(s, 11, d[7], 1'b0, a == b, a >= b), "R7");
            end
        run(OP_CMP, 8'h42, 8'h42, 8'h08, 8'h42, 8'h2B, "R7");

        // R8 logic / pass, R11 R12 R13 bit ops
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 17) begin
                logic [7:0] s, r, m;
                s = 8'(a + b * 11);
                m = 8'(a) & 8'(b);
                r = 8'(a) & 8'(b);
                run(OP_AND, 8'(a), 8'(b), s, r, fl(s, 10, r[7], 1'b0, r == 0, 1'b0), "R8");
                r = 8'(a) | 8'(b);
                run(OP_OR, 8'(a), 8'(b), s, r, fl(s, 10, r[7], 1'b0, r == 0, 1'b0), "R8");
                r = 8'(a) ^ 8'(b);
                run(OP_XOR, 8'(a), 8'(b), s, r, fl(s, 10, r[7], 1'b0, r == 0, 1'b0), "R8");
                run(OP_BITM, 8'(a), 8'(b), s, 8'(a), fl(s, 14, b[7], b[6], m == 0, 1'b0), "R11");
                run(OP_BITI, 8'(a), 8'(b), s, 8'(a), fl(s, 2, 1'b0, 1'b0, m == 0, 1'b0), "R12");
                r = 8'(b) | 8'(a);
                run(OP_TSET, 8'(a), 8'(b), s, r, fl(s, 2, 1'b0, 1'b0, m == 0, 1'b0), "R13");
                r = 8'(b) & ~8'(a);
                run(OP_TCLR, 8'(a), 8'(b), s, r, fl(s, 2, 1'b0, 1'b0, m == 0, 1'b0), "R13");
            end
        // R8 unused op codes leave everything alone
        for (int o = 17; o < 32; o++)
            run(5'(o), 8'h3C, 8'h00, 8'hC1, 8'h3C, 8'hE1, "R8");

        // R8 pass, R9 inc/dec, R10 shifts and rotates
        for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++) begin
                logic [7:0] s, r;
                s = 8'(b * 13) & 8'hFE | 8'(c);
                run(OP_PASS, 8'h5A, 8'(b), s, 8'(b), fl(s, 10, b[7], 1'b0, b == 0, 1'b0), "R8");
                r = 8'(b + 1);
                run(OP_INC, 8'h00, 8'(b), s, r, fl(s, 10, r[7], 1'b0, r == 0, 1'b0), "R9");
                r = 8'(b - 1);
                run(OP_DEC, 8'h00, 8'(b), s, r, fl(s, 10, r[7], 1'b0, r == 0, 1'b0), "R9");
                r = 8'((b * 2) % 256);
                run(OP_SHL, 8'h00, 8'(b), s, r, fl(s, 11, r[7], 1'b0, r == 0, b >= 128), "R10");
                r = 8'(b / 2);
                run(OP_SHR, 8'h00, 8'(b), s, r, fl(s, 11, 1'b0, 1'b0, r == 0, b[0]), "R10");
                r = 8'((b * 2) % 256 + c);
                run(OP_ROTL, 8'h00, 8'(b), s, r, fl(s, 11, r[7], 1'b0, r == 0, b >= 128), "R10");
                r = 8'(b / 2 + c * 128);
                run(OP_ROTR, 8'h00, 8'(b), s, r, fl(s, 11, r[7], 1'b0, r == 0, b[0]), "R10");
            end

        // R4 corner: 99 + 0 with carry in wraps to 00 with carry out
        run(OP_ADC, 8'h99, 8'h00, 8'h09, 8'h00, 8'h2B, "R4");
        // R6 corner: 00 - 01 borrows to 99
        run(OP_SBC, 8'h00, 8'h01, 8'h09, 8'h99, 8'hA8, "R6");
        if (from_bcd(8'h99) != 99) begin fails++; $display("FAIL bench bcd helper"); end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule